// File: doc/BRIEF.md
# Audio Sample DMA Channel with Handshaked Stop

This block is one direction of a DMA path for audio. It moves 32-bit sample words between a peripheral and memory over a simple bus with a request line and a single-cycle acknowledge. Software loads a start address and a byte count while the channel is idle, then issues an enable pulse. The mode input, sampled at enable, selects the direction:

- **Transmit:** memory is read into an internal word FIFO, and the peripheral pulls words from that FIFO.
- **Receive:** the peripheral pushes words into the FIFO, and the channel writes them to memory.

The channel can be stopped early. A stop request raises a stop flag that software can read. The in-flight bus beat is never abandoned. In receive mode, any words already buffered are written out before the channel counts as stopped. Only then does hardware lower the flag and, if enabled, pulse the termination interrupt. While the flag is high, enable pulses are ignored. The remaining-byte count stays readable, so software can see how much was left. To resume, software reloads the address and count, then enables again.

Top module: `adma_chan`

## Requirements
- R1: After synchronous reset, the following are all 0:
  - bus_req, stop_bit, remain, done_flag, irq_done, irq_term, overrun and underrun.
- R2: A ld_valid pulse while idle loads the address and loads remain with ld_bytes with its two low bits forced to 0. A ld_valid pulse while the channel is active changes nothing.
- R3: Starting and stepping a transfer:
  - An en_req pulse while idle, with remain nonzero, starts a transfer at the loaded address.
  - bus_req is held with a stable address until bus_ack.
  - Each acknowledged beat raises the address by 4 and lowers remain by 4.
- R4: In transmit mode (mode_rx=0 at enable):
  - Beats are reads (bus_we=0), issued while the FIFO has room, and bus_rdata is stored in the FIFO.
  - A per_rd pulse returns the oldest word on per_rdata one cycle later.
- R5: In receive mode (mode_rx=1 at enable):
  - A per_wr pulse while running stores per_wdata in the FIFO.
  - Beats are writes (bus_we=1) of the FIFO words, in arrival order.
- R6: When remain reaches 0 after a beat:
  - done_flag is set, and the channel returns to idle.
  - If irq_done_en is 1, irq_done pulses for one cycle.
  - If irq_done_en is 0, no irq_done pulse appears.
- R7: A stop request while a beat is pending keeps bus_req until that beat is acknowledged. That beat is counted, and no later beat starts in transmit mode.
- R8: stop_bit reads 1 from the cycle after a stop request until the channel has fully stopped. Hardware then clears it.
- R9: In receive mode, stop_bit clears only after every buffered word has been written to memory, bounded by remain.
- R10: An en_req pulse while stop_bit is 1 has no effect. No transfer starts afterwards.
- R11: irq_term pulses for one cycle in the cycle stop_bit falls, if irq_term_en is 1. It never pulses while stop_bit is still 1.
- R12: Receive-FIFO overflow:
  - The FIFO holds 8 words.
  - A per_wr pulse while running with the FIFO full drops the word and sets the sticky overrun flag.
- R13: Transmit-FIFO underflow and sticky-flag clearing:
  - A per_rd pulse with the transmit FIFO empty returns 0 and sets the sticky underrun flag.
  - The FIFO is emptied when a stop completes.
  - An accepted enable clears both sticky flags.
- R14: After a stop, loading a new address and count and then enabling resumes the transfer from the new address, through to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rx | input | 1 | 1 selects receive, 0 selects transmit; sampled at enable |
| ld_valid | input | 1 | Load address and byte count (idle only) |
| ld_addr | input | ADDR_W | Start address to load |
| ld_bytes | input | CNT_W | Byte count to load |
| en_req | input | 1 | Enable pulse |
| stop_req | input | 1 | Forced-stop request pulse |
| irq_done_en | input | 1 | Enables the completion interrupt |
| irq_term_en | input | 1 | Enables the termination interrupt |
| per_wr | input | 1 | Peripheral pushes a word (receive) |
| per_wdata | input | DATA_W | Word pushed by the peripheral |
| per_rd | input | 1 | Peripheral pulls a word (transmit) |
| per_rdata | output | DATA_W | Word returned to the peripheral, registered |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Single-cycle beat acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| remain | output | CNT_W | Remaining byte count |
| stop_bit | output | 1 | Stop still in progress |
| done_flag | output | 1 | Last transfer completed normally |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_term | output | 1 | Termination interrupt pulse |
| overrun | output | 1 | Sticky receive overflow flag |
| underrun | output | 1 | Sticky transmit underflow flag |

## Verification
The properties rely on these assumptions about the environment:
- bus_ack only ever pulses for a single cycle while bus_req is high.
- mode_rx and the two interrupt enables stay constant from enable until the channel is idle again.
- Loaded byte counts are nonzero.

The bench keeps within these limits:
- Its bus responder raises bus_ack only when it sees bus_req, and drops it the next cycle.
- Mode and enables are set before each enable pulse.
- Stalls are made by withholding bus_ack, never by lowering bus_req.

// File: rtl/adma_pkg.sv
package adma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT_BUS,
    ST_FLUSH,
    ST_STOPPED
  } adma_state_e;
endpackage

// File: rtl/adma_fifo.sv
module adma_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/adma_ctrl.sv
module adma_ctrl
  import adma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int BEAT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rx,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_bytes,
  input  logic              en_req,
  input  logic              stop_req,
  input  logic              irq_done_en,
  input  logic              irq_term_en,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic              bus_ack,
  output adma_state_e       st,
  output logic              mode_q,
  output logic              en_ok,
  output logic              beat,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CNT_W-1:0]  remain,
  output logic              stop_bit,
  output logic              done_flag,
  output logic              irq_done,
  output logic              irq_term
);
  localparam logic [CNT_W-1:0]  STEP_C = CNT_W'(BEAT);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BEAT);
  localparam logic [CNT_W-1:0]  CMASK  = ~CNT_W'(BEAT - 1);

  logic        can_issue;
  logic        last_beat;
  adma_state_e stop_dest;

  assign en_ok     = en_req && (st == ST_IDLE) && (remain != '0);
  assign beat      = bus_req & bus_ack;
  assign can_issue = mode_q ? ~fifo_empty : ~fifo_full;
  assign last_beat = (remain == STEP_C);
  assign stop_dest = mode_q ? ST_FLUSH : ST_STOPPED;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode_q    <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      remain    <= '0;
      stop_bit  <= 1'b0;
      done_flag <= 1'b0;
      irq_done  <= 1'b0;
      irq_term  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_term <= 1'b0;
      if (beat) begin
        bus_req  <= 1'b0;
        bus_addr <= bus_addr + STEP_A;
        remain   <= remain - STEP_C;
      end
      unique case (st)
        ST_IDLE: begin
          if (ld_valid) begin
            bus_addr <= ld_addr;
            remain   <= ld_bytes & CMASK;
          end
          if (en_ok) begin
            st        <= ST_RUN;
            mode_q    <= mode_rx;
            done_flag <= 1'b0;
          end
        end
        ST_RUN: begin
          if (beat) begin
            if (last_beat) begin
              done_flag <= 1'b1;
              irq_done  <= irq_done_en;
              st        <= ST_IDLE;
            end else if (stop_req) begin
              stop_bit <= 1'b1;
              st       <= stop_dest;
            end
          end else if (stop_req) begin
            stop_bit <= 1'b1;
            st       <= bus_req ? ST_WAIT_BUS : stop_dest;
          end else if (!bus_req && can_issue) begin
            bus_req <= 1'b1;
            bus_we  <= mode_q;
          end
        end
        ST_WAIT_BUS: begin
          if (beat) st <= stop_dest;
        end
        ST_FLUSH: begin
          if (!bus_req) begin
            if (!fifo_empty && remain != '0) begin
              bus_req <= 1'b1;
              bus_we  <= 1'b1;
            end else begin
              st <= ST_STOPPED;
            end
          end
        end
        ST_STOPPED: begin
          stop_bit <= 1'b0;
          irq_term <= irq_term_en;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adma_chan.sv
module adma_chan
  import adma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rx,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_bytes,
  input  logic              en_req,
  input  logic              stop_req,
  input  logic              irq_done_en,
  input  logic              irq_term_en,
  input  logic              per_wr,
  input  logic [DATA_W-1:0] per_wdata,
  input  logic              per_rd,
  output logic [DATA_W-1:0] per_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  remain,
  output logic              stop_bit,
  output logic              done_flag,
  output logic              irq_done,
  output logic              irq_term,
  output logic              overrun,
  output logic              underrun
);
  localparam int BEAT = DATA_W / 8;

  adma_state_e       st;
  logic              mode_q, en_ok, beat;
  logic              f_empty, f_full, f_push, f_pop, f_clr;
  logic [DATA_W-1:0] f_din, f_dout;
  logic              running;

  adma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT(BEAT)) u_ctrl (
    .clk(clk), .rst(rst), .mode_rx(mode_rx),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_bytes(ld_bytes),
    .en_req(en_req), .stop_req(stop_req),
    .irq_done_en(irq_done_en), .irq_term_en(irq_term_en),
    .fifo_empty(f_empty), .fifo_full(f_full), .bus_ack(bus_ack),
    .st(st), .mode_q(mode_q), .en_ok(en_ok), .beat(beat),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .remain(remain), .stop_bit(stop_bit), .done_flag(done_flag),
    .irq_done(irq_done), .irq_term(irq_term)
  );

  assign running = (st == ST_RUN);
  assign f_push  = mode_q ? (per_wr & running) : beat;
  assign f_pop   = mode_q ? beat : per_rd;
  assign f_din   = mode_q ? per_wdata : bus_rdata;
  assign f_clr   = en_ok | (st == ST_STOPPED);

  adma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(f_clr),
    .push(f_push), .din(f_din), .pop(f_pop),
    .dout(f_dout), .empty(f_empty), .full(f_full)
  );

  assign bus_wdata = f_dout;

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun   <= 1'b0;
      underrun  <= 1'b0;
      per_rdata <= '0;
    end else begin
      if (en_ok) begin
        overrun  <= 1'b0;
        underrun <= 1'b0;
      end else begin
        if (mode_q && running && per_wr && f_full) overrun <= 1'b1;
        if (!mode_q && per_rd && f_empty)          underrun <= 1'b1;
      end
      if (!mode_q && per_rd) per_rdata <= f_empty ? '0 : f_dout;
    end
  end
endmodule

// File: rtl/adma_chan_chk.sv
module adma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  remain,
  input logic              stop_bit,
  input logic              irq_term,
  input logic              irq_term_en,
  input logic              irq_done,
  input logic              underrun,
  input logic [DATA_W-1:0] per_rdata
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> remain == $past(remain) - STEP);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> (remain == '0) && !bus_req);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_bit) |-> !bus_req);

  p_term_at_fall_r11: assert property (@(posedge clk) disable iff (rst)
    irq_term |-> $fell(stop_bit));

  p_fall_raises_term_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_bit) && irq_term_en |-> irq_term);

  p_underrun_zero_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> per_rdata == '0);
endmodule

bind adma_chan adma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/adma_chan_test.sv
`timescale 1ns/100ps
module adma_chan_test;
  localparam int AW = 32, CW = 16, DW = 32;
  localparam logic [31:0] RMASK = 32'h5A5A_0000;
  // {rx, ack latency, words, start address}
  localparam logic [47:0] VEC [4] = '{
    {1'b0, 3'd0, 12'd5, 32'h0000_1000},
    {1'b1, 3'd1, 12'd6, 32'h0000_2000},
    {1'b0, 3'd2, 12'd3, 32'h0000_3004},
    {1'b1, 3'd0, 12'd4, 32'h0000_0040}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic mode_rx = 0, ld_valid = 0, en_req = 0, stop_req = 0;
  logic irq_done_en = 1, irq_term_en = 1, per_wr = 0, per_rd = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [CW-1:0] ld_bytes = '0;
  logic [DW-1:0] per_wdata = '0, per_rdata, bus_wdata, bus_rdata;
  logic bus_req, bus_we, bus_ack, stop_bit, done_flag, irq_done, irq_term, overrun, underrun;
  logic [AW-1:0] bus_addr;
  logic [CW-1:0] remain;

  adma_chan #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .FIFO_DEPTH(8)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, mchecks = 0, merrors = 0;
  int beats = 0, irqd_cnt = 0, irqt_cnt = 0, wait_cnt = 0;
  int ack_lat = 0, beat_base = 0;
  logic [31:0] base_addr = '0, pat_base = '0;
  logic cur_rx = 1'b0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder and interrupt counter
  initial begin
    bus_ack = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (irq_done) irqd_cnt++;
      if (irq_term) irqt_cnt++;
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req && !rst) begin
        if (wait_cnt >= ack_lat) begin
          wait_cnt = 0;
          bus_ack = 1'b1;
          bus_rdata = bus_addr ^ RMASK;
          mchecks++;
          if (bus_addr !== base_addr + 32'(4 * (beats - beat_base))) begin
            merrors++;
            $display("FAIL R3 address actual=%0h expected=%0h", bus_addr,
                     base_addr + 32'(4 * (beats - beat_base)));
          end
          mchecks++;
          if (bus_we !== cur_rx) begin
            merrors++;
            $display("FAIL R5 direction actual=%0b expected=%0b", bus_we, cur_rx);
          end
          if (bus_we) begin
            mchecks++;
            if (bus_wdata !== pat_base + 32'(beats - beat_base)) begin
              merrors++;
              $display("FAIL R5 write data actual=%0h expected=%0h", bus_wdata,
                       pat_base + 32'(beats - beat_base));
            end
          end
          beats++;
        end else wait_cnt++;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [31:0] a, input logic [15:0] b);
    ld_valid = 1; ld_addr = a; ld_bytes = b;
    tick();
    ld_valid = 0;
  endtask

  task automatic enable();
    en_req = 1;
    tick();
    en_req = 0;
  endtask

  task automatic stop();
    stop_req = 1;
    tick();
    stop_req = 0;
  endtask

  task automatic push_words(input int n, input bit back2back);
    for (int k = 0; k < n; k++) begin
      per_wr = 1; per_wdata = pat_base + 32'(k);
      tick();
      per_wr = 0;
      if (!back2back) tick();
    end
  endtask

  task automatic pull(output logic [31:0] d);
    per_rd = 1;
    tick();
    per_rd = 0;
    d = per_rdata;
  endtask

  task automatic wait_done(input string req);
    bit ok = 0;
    for (int c = 0; c < 2000; c++) begin
      tick();
      if (done_flag) begin ok = 1; break; end
    end
    chk(ok, req, {63'd0, ok}, 64'd1);
  endtask

  task automatic wait_stop(output bit irq_at, output int beats_at);
    bit ok = 0;
    irq_at = 0; beats_at = 0;
    for (int c = 0; c < 5000; c++) begin
      tick();
      if (!stop_bit) begin
        ok = 1; irq_at = irq_term; beats_at = beats - beat_base;
        break;
      end
    end
    chk(ok, "R8 stop bit clears", {63'd0, ok}, 64'd1);
  endtask

  task automatic setup(input bit rx, input int lat, input logic [31:0] a, input logic [31:0] pat);
    mode_rx = rx; cur_rx = rx; ack_lat = lat;
    base_addr = a; pat_base = pat; beat_base = beats;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit irq_at;
    int nb, irq0;
    bit quiet;

    repeat (4) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(bus_req == 0 && stop_bit == 0 && done_flag == 0, "R1 reset controls",
        {bus_req, stop_bit, done_flag}, 0);
    chk(remain == 0, "R1 reset remain", remain, 0);
    chk(!overrun && !underrun && !irq_done && !irq_term, "R1 reset flags",
        {overrun, underrun, irq_done, irq_term}, 0);

    // R2 low bits of the count are dropped
    load(32'h100, 16'd13);
    chk(remain == 16'd12, "R2 count masking", remain, 12);

    // table-driven normal runs: R3 R4 R5 R6
    for (int i = 0; i < 4; i++) begin
      logic [47:0] v;
      int words;
      v = VEC[i];
      words = int'(v[43:32]);
      setup(v[47], int'(v[46:44]), v[31:0], 32'hC0DE_0000 + 32'(i * 256));
      load(v[31:0], 16'(words * 4));
      irq0 = irqd_cnt;
      enable();
      if (v[47]) push_words(words, 0);
      wait_done("R6 completion reached");
      tick();
      chk(beats - beat_base == words, "R3 beat count", beats - beat_base, words);
      chk(remain == 0, "R6 remain zero", remain, 0);
      chk(irqd_cnt == irq0 + 1, "R6 done interrupt", irqd_cnt - irq0, 1);
      if (!v[47]) begin
        for (int k = 0; k < words; k++) begin
          pull(d);
          chk(d == ((v[31:0] + 32'(4 * k)) ^ RMASK), "R4 transmit data", d,
              (v[31:0] + 32'(4 * k)) ^ RMASK);
        end
      end
    end

    // R6 with completion interrupt disabled
    irq_done_en = 0;
    setup(0, 0, 32'h7000, 0);
    load(32'h7000, 16'd4);
    irq0 = irqd_cnt;
    enable();
    wait_done("R6 completion without irq");
    tick();
    chk(irqd_cnt == irq0, "R6 irq masked", irqd_cnt - irq0, 0);
    irq_done_en = 1;

    // transmit forced stop with a stalled beat: R7 R8 R10 R11 R2
    setup(0, 100000, 32'h8000, 0);
    load(32'h8000, 16'd32);
    irq0 = irqt_cnt;
    enable();
    for (int c = 0; c < 20 && !bus_req; c++) tick();
    stop();
    chk(stop_bit == 1, "R8 stop bit set", stop_bit, 1);
    enable();
    load(32'hDEAD_0000, 16'hFFF0);
    chk(remain == 16'd32, "R2 load ignored while active", remain, 32);
    repeat (5) tick();
    chk(stop_bit == 1 && bus_req == 1, "R7 beat kept pending", {stop_bit, bus_req}, 2'b11);
    chk(irqt_cnt == irq0, "R11 no irq at request", irqt_cnt - irq0, 0);
    ack_lat = 0;
    wait_stop(irq_at, nb);
    chk(nb == 1, "R7 pending beat completed", nb, 1);
    chk(irq_at == 1, "R11 irq at stop", irq_at, 1);
    tick();
    chk(remain == 16'd28, "R7 remain after stop", remain, 28);
    quiet = 1;
    for (int c = 0; c < 10; c++) begin
      tick();
      if (bus_req) quiet = 0;
    end
    chk(quiet && beats - beat_base == 1 && !done_flag, "R10 enable during stop ignored",
        {quiet, done_flag}, 2'b10);
    pull(d);
    chk(d == 0 && underrun == 1, "R13 underrun after stop", {underrun, d}, {1'b1, 32'd0});

    // receive forced stop with flush: R9 R13
    setup(1, 100000, 32'h6000, 32'hAB00_0000);
    load(32'h6000, 16'd32);
    enable();
    chk(underrun == 0, "R13 sticky cleared by enable", underrun, 0);
    push_words(4, 1);
    stop();
    chk(stop_bit == 1, "R8 stop bit set receive", stop_bit, 1);
    ack_lat = 0;
    wait_stop(irq_at, nb);
    chk(nb == 4, "R9 buffered words flushed", nb, 4);
    chk(irq_at == 1, "R11 irq at receive stop", irq_at, 1);
    chk(remain == 16'd16, "R9 remain after flush", remain, 16);

    // resume: R14
    setup(1, 0, 32'h5000, 32'hAB10_0000);
    load(32'h5000, 16'd16);
    enable();
    push_words(4, 0);
    wait_done("R14 resumed run completes");
    tick();
    chk(beats - beat_base == 4 && remain == 0, "R14 resumed beats", beats - beat_base, 4);

    // receive overflow: R12
    setup(1, 100000, 32'h9000, 32'hCD00_0000);
    load(32'h9000, 16'd64);
    enable();
    push_words(10, 1);
    tick();
    chk(overrun == 1, "R12 overrun set", overrun, 1);
    ack_lat = 0;
    repeat (60) tick();
    chk(beats - beat_base == 8, "R12 extra words dropped", beats - beat_base, 8);
    chk(remain == 16'd32, "R12 remain", remain, 32);
    stop();
    wait_stop(irq_at, nb);
    chk(overrun == 1, "R12 overrun sticky", overrun, 1);

    repeat (5) tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end
endmodule